// File: doc/BRIEF.md
# Relative Conditional Branch Resolver

This block settles the eight relative conditional branches of a classic 8-bit accumulator processor. A sequencer hands it one fetched instruction at a time: the opcode byte, the one-byte signed displacement, the address of the opcode, and the four status flags (negative, overflow, carry, zero). The block decides whether the branch is taken. It returns the address of the next instruction and the number of clock cycles the instruction costs. It also marks a taken branch that lands back on its own opcode, which is the usual idiom for a deliberate endless loop.

The request side and the result side each use a valid/ready pair. A request is accepted when both request valid and request ready are high at a rising clock edge. The result is registered, so it appears one clock later and stays there until the consumer takes it. A new request can be accepted in the same cycle that the previous result is consumed, which lets the sequencer step one instruction per clock.

Top module: `cond_branch_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, `out_valid` is low after that edge. The reset is synchronous and active low.
- R2: An opcode is a branch when bits 4:0 equal 10000. Bits 7:6 pick the tested flag: 00 picks N, 01 picks V, 10 picks C and 11 picks Z. The branch is taken when that flag equals opcode bit 5. This gives taken on 0x10 when N=0, 0x30 when N=1, 0x50 when V=0, 0x70 when V=1, 0x90 when C=0, 0xB0 when C=1, 0xD0 when Z=0 and 0xF0 when Z=1. `out_taken` reports the decision.
- R3: For a branch that is not taken, `out_next_pc` is `in_pc`+2 and `out_cycles` is 2.
- R4: For a taken branch, `out_next_pc` is `in_pc`+2 plus the sign-extended displacement. The displacement is read as two's complement, so 0x80 to 0xFF are -128 to -1.
- R5: A taken branch whose target has the same high byte as `in_pc`+2 costs 3 cycles.
- R6: A taken branch whose target has a different high byte from `in_pc`+2 costs 4 cycles.
- R7: `out_self_loop` is high exactly when the branch is taken and the displacement is 0xFE (-2). A branch with displacement 0xFE that is not taken leaves it low.
- R8: For a non-branch opcode, `out_unsupported` is high, `out_next_pc` equals `in_pc`, `out_cycles` is 0, and both `out_taken` and `out_self_loop` are low. For a branch opcode, `out_unsupported` is low.
- R9: `in_ready` equals (not `out_valid`) or `out_ready`. An accepted request produces `out_valid` high with its results after the next rising edge. `out_valid` falls after an edge where the result is consumed and no new request is accepted.
- R10: While `out_valid` is high and `out_ready` is low, every result output holds its value and no new request is accepted.
- R11: All address arithmetic wraps modulo 65536, both for the fall-through address and for the branch target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can accept a request this cycle |
| in_opcode | input | 8 | Fetched opcode byte |
| in_disp | input | 8 | Signed displacement operand |
| in_pc | input | 16 | Address of the opcode byte |
| flag_n | input | 1 | Negative status flag |
| flag_v | input | 1 | Overflow status flag |
| flag_c | input | 1 | Carry status flag |
| flag_z | input | 1 | Zero status flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_next_pc | output | 16 | Address of the next instruction |
| out_taken | output | 1 | Branch condition was met |
| out_cycles | output | 3 | Clock cycles consumed by the instruction |
| out_self_loop | output | 1 | Taken branch targets its own opcode |
| out_unsupported | output | 1 | Opcode is not a conditional branch |

## Verification
Every result field is due exactly one rising edge after the edge that accepts its request. `in_ready` is combinational and is due in the same cycle as `out_valid` and `out_ready`. The bench's reference model advances on the same rising edge as the design, using only the inputs it drove and its own prediction of the valid state. The bench compares the model with the outputs at the following falling edge, so every check looks at the cycle in which the result must be present. During stalls with `out_ready` held low, the model keeps its prediction unchanged, and the same per-clock comparison confirms that the held results do not move.

// File: rtl/cbu_pkg.sv
// Package: shared constants and types for the conditional branch unit.
// Assumes 8-bit opcodes; all address widths are set on the modules.
package cbu_pkg;

    localparam int OP_W = 8;

    // Low opcode bits that mark a member of the branch group
    localparam int          SIG_W   = 5;
    localparam logic [4:0]  BR_SIG  = 5'b10000;

    // Cycle costs of the four outcome kinds
    localparam int COST_BAD   = 0;
    localparam int COST_NOT   = 2;
    localparam int COST_SAME  = 3;
    localparam int COST_CROSS = 4;

    // Bytes in one branch instruction (opcode + displacement)
    localparam int INSN_BYTES = 2;

    // Flag chosen by opcode bits 7:6
    typedef enum logic [1:0] {
        SEL_NEG = 2'b00,
        SEL_OVF = 2'b01,
        SEL_CRY = 2'b10,
        SEL_ZER = 2'b11
    } flag_sel_e;

endpackage

// File: rtl/cbu_cond_decode.sv
// Module: cbu_cond_decode
// Classifies an opcode as a branch and evaluates its condition.
// Assumes the flag-select field sits in bits 7:6 and the wanted
// flag value in bit 5; purely combinational.
module cbu_cond_decode
    import cbu_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    input  logic            flag_n,
    input  logic            flag_v,
    input  logic            flag_c,
    input  logic            flag_z,
    output logic            is_branch,
    output logic            take
);

    localparam int SEL_HI  = OP_W - 1;
    localparam int SEL_LO  = OP_W - 2;
    localparam int POL_BIT = OP_W - 3;

    flag_sel_e sel;
    logic      chosen;

    assign sel       = flag_sel_e'(opcode[SEL_HI:SEL_LO]);
    assign is_branch = (opcode[SIG_W-1:0] == BR_SIG);

    // Pick the tested flag from the select field
    always_comb begin
        case (sel)
            SEL_NEG: chosen = flag_n;
            SEL_OVF: chosen = flag_v;
            SEL_CRY: chosen = flag_c;
            default: chosen = flag_z;
        endcase
    end

    // Taken when the tested flag matches the polarity bit
    always_comb begin
        take = is_branch && (chosen == opcode[POL_BIT]);
    end

endmodule

// File: rtl/cbu_target_calc.sv
// Module: cbu_target_calc
// Computes fall-through and target addresses, the page-crossing
// flag and whether the target is the opcode itself.
// Assumes ADDR_W > DISP_W > 0 and ADDR_W > PAGE_W; arithmetic wraps.
module cbu_target_calc #(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 8,
    parameter int PAGE_W = 8,
    parameter int STEP   = 2
) (
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] fall_thru,
    output logic [ADDR_W-1:0] target,
    output logic              page_cross,
    output logic              lands_on_self
);

    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_ext;

    // Sign-extend the displacement to address width
    always_comb begin
        disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
    end

    // Address after the instruction and the branch target
    always_comb begin
        fall_thru = op_addr + ADDR_W'(STEP);
        target    = fall_thru + disp_ext;
    end

    // Page comparison on the high part and self-target detection
    always_comb begin
        page_cross    = (fall_thru[ADDR_W-1:PAGE_W] != target[ADDR_W-1:PAGE_W]);
        lands_on_self = (target == op_addr);
    end

endmodule

// File: rtl/cbu_cycle_cost.sv
// Module: cbu_cycle_cost
// Maps the branch outcome to the instruction's cycle count.
// Assumes CYC_W is wide enough for the largest cost; combinational.
module cbu_cycle_cost
    import cbu_pkg::*;
#(
    parameter int CYC_W = 3
) (
    input  logic             is_branch,
    input  logic             take,
    input  logic             page_cross,
    output logic [CYC_W-1:0] cycles
);

    // Select the cost for the outcome kind
    always_comb begin
        if (!is_branch)
            cycles = CYC_W'(COST_BAD);
        else if (!take)
            cycles = CYC_W'(COST_NOT);
        else if (page_cross)
            cycles = CYC_W'(COST_CROSS);
        else
            cycles = CYC_W'(COST_SAME);
    end

endmodule

// File: rtl/cond_branch_unit.sv
// Module: cond_branch_unit
// Resolves one relative conditional branch per accepted request and
// returns a registered result one clock later, held until consumed.
// Assumes a synchronous active-low reset; flags are sampled with the
// request.
module cond_branch_unit
    import cbu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 8,
    parameter int PAGE_W = 8,
    parameter int CYC_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [OP_W-1:0]   in_opcode,
    input  logic [DISP_W-1:0] in_disp,
    input  logic [ADDR_W-1:0] in_pc,
    input  logic              flag_n,
    input  logic              flag_v,
    input  logic              flag_c,
    input  logic              flag_z,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_next_pc,
    output logic              out_taken,
    output logic [CYC_W-1:0]  out_cycles,
    output logic              out_self_loop,
    output logic              out_unsupported
);

    logic              is_branch;
    logic              take;
    logic [ADDR_W-1:0] fall_thru;
    logic [ADDR_W-1:0] target;
    logic              page_cross;
    logic              lands_on_self;
    logic [CYC_W-1:0]  cost;
    logic [ADDR_W-1:0] next_pc;
    logic              accept;

    cbu_cond_decode u_decode (
        .opcode    (in_opcode),
        .flag_n    (flag_n),
        .flag_v    (flag_v),
        .flag_c    (flag_c),
        .flag_z    (flag_z),
        .is_branch (is_branch),
        .take      (take)
    );

    cbu_target_calc #(
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W),
        .PAGE_W (PAGE_W),
        .STEP   (INSN_BYTES)
    ) u_target (
        .op_addr       (in_pc),
        .disp          (in_disp),
        .fall_thru     (fall_thru),
        .target        (target),
        .page_cross    (page_cross),
        .lands_on_self (lands_on_self)
    );

    cbu_cycle_cost #(
        .CYC_W (CYC_W)
    ) u_cost (
        .is_branch  (is_branch),
        .take       (take),
        .page_cross (page_cross),
        .cycles     (cost)
    );

    // Handshake: free when empty or when the held result leaves now
    always_comb begin
        in_ready = !out_valid || out_ready;
        accept   = in_valid && in_ready;
    end

    // Next address: pass-through, fall-through or target
    always_comb begin
        if (!is_branch)
            next_pc = in_pc;
        else if (take)
            next_pc = target;
        else
            next_pc = fall_thru;
    end

    // Result-valid flag
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else if (accept)
            out_valid <= 1'b1;
        else if (out_ready)
            out_valid <= 1'b0;
    end

    // Result registers, loaded only on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_next_pc     <= '0;
            out_taken       <= 1'b0;
            out_cycles      <= '0;
            out_self_loop   <= 1'b0;
            out_unsupported <= 1'b0;
        end else if (accept) begin
            out_next_pc     <= next_pc;
            out_taken       <= take;
            out_cycles      <= cost;
            out_self_loop   <= take && lands_on_self;
            out_unsupported <= !is_branch;
        end
    end

endmodule

// File: rtl/cbu_checker.sv
// Module: cbu_checker
// Property checks on the ports of cond_branch_unit, attached by bind.
module cbu_checker #(
    parameter int ADDR_W = 16,
    parameter int CYC_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_next_pc,
    input logic              out_taken,
    input logic [CYC_W-1:0]  out_cycles,
    input logic              out_self_loop,
    input logic              out_unsupported
);

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !out_valid); // R1

    AST_NOT_TAKEN_COST: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_unsupported && !out_taken |-> out_cycles == CYC_W'(2)); // R3

    AST_TAKEN_COST: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_taken |-> (out_cycles == CYC_W'(3) || out_cycles == CYC_W'(4))); // R5

    AST_SELF_NEEDS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_self_loop |-> out_taken); // R7

    AST_BAD_OPCODE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_unsupported |-> (out_cycles == '0 && !out_taken && !out_self_loop)); // R8

    AST_ACCEPT_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid); // R9

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_next_pc) && $stable(out_cycles)
            && $stable(out_taken) && $stable(out_self_loop) && $stable(out_unsupported)); // R10

endmodule

bind cond_branch_unit cbu_checker #(
    .ADDR_W (ADDR_W),
    .CYC_W  (CYC_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .in_valid        (in_valid),
    .in_ready        (in_ready),
    .out_valid       (out_valid),
    .out_ready       (out_ready),
    .out_next_pc     (out_next_pc),
    .out_taken       (out_taken),
    .out_cycles      (out_cycles),
    .out_self_loop   (out_self_loop),
    .out_unsupported (out_unsupported)
);

// File: tb/cond_branch_unit_tb.sv
module cond_branch_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_opcode = 8'h00;
    logic [7:0]  in_disp = 8'h00;
    logic [15:0] in_pc = 16'h0000;
    logic        flag_n = 1'b0, flag_v = 1'b0, flag_c = 1'b0, flag_z = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_next_pc;
    logic        out_taken;
    logic [2:0]  out_cycles;
    logic        out_self_loop;
    logic        out_unsupported;

    always #4 clk = ~clk;   // 125 MHz

    cond_branch_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_opcode(in_opcode), .in_disp(in_disp), .in_pc(in_pc),
        .flag_n(flag_n), .flag_v(flag_v), .flag_c(flag_c), .flag_z(flag_z),
        .out_valid(out_valid), .out_ready(out_ready), .out_next_pc(out_next_pc),
        .out_taken(out_taken), .out_cycles(out_cycles),
        .out_self_loop(out_self_loop), .out_unsupported(out_unsupported)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    bit rnd_ready = 0;

    // reference model state
    bit m_valid = 0;
    int m_pc, m_cyc;
    bit m_taken, m_self, m_uns, m_cross, m_wrap;
    bit acc_seen = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural expectation from the requirements
    task automatic ref_calc(input logic [7:0] op, input logic [7:0] d, input logic [15:0] pc,
                            input bit n, input bit v, input bit c, input bit z,
                            output int npc, output int cyc, output bit tk, output bit sl,
                            output bit un, output bit cr, output bit wr);
        bit cond;
        int fall, sd, raw;
        un = 0; cond = 0;
        case (op)
            8'h10: cond = !n;
            8'h30: cond = n;
            8'h50: cond = !v;
            8'h70: cond = v;
            8'h90: cond = !c;
            8'hB0: cond = c;
            8'hD0: cond = !z;
            8'hF0: cond = z;
            default: un = 1;
        endcase
        sd   = (d >= 128) ? int'(d) - 256 : int'(d);
        raw  = int'(pc) + 2;
        fall = raw % 65536;
        wr = 0; cr = 0; sl = 0; tk = 0;
        if (un) begin
            npc = int'(pc); cyc = 0;
        end else if (!cond) begin
            npc = fall; cyc = 2; wr = (raw >= 65536);
        end else begin
            tk  = 1;
            raw = int'(pc) + 2 + sd;
            wr  = (raw >= 65536) || (raw < 0);
            npc = (raw + 65536) % 65536;
            cr  = (npc / 256) != (fall / 256);
            cyc = cr ? 4 : 3;
            sl  = (d == 8'hFE);
        end
    endtask

    // model advances on the same edge as the design
    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid = 0;
            acc_seen = 0;
        end else begin
            acc_seen = in_valid && (!m_valid || out_ready);
            if (acc_seen) begin
                ref_calc(in_opcode, in_disp, in_pc, flag_n, flag_v, flag_c, flag_z,
                         m_pc, m_cyc, m_taken, m_self, m_uns, m_cross, m_wrap);
                m_valid = 1;
            end else if (out_ready) begin
                m_valid = 0;
            end
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R9 out_valid", out_valid, m_valid);
            chk("R9 in_ready", in_ready, !m_valid || out_ready);
            if (m_valid) begin
                chk("R2 taken", out_taken, m_taken);
                chk("R8 unsupported", out_unsupported, m_uns);
                chk("R7 self_loop", out_self_loop, m_self);
                if (m_uns)          chk("R8 next_pc", out_next_pc, m_pc);
                else if (m_wrap)    chk("R11 next_pc", out_next_pc, m_pc);
                else if (m_taken)   chk("R4 next_pc", out_next_pc, m_pc);
                else                chk("R3 next_pc", out_next_pc, m_pc);
                if (m_uns)          chk("R8 cycles", out_cycles, m_cyc);
                else if (!m_taken)  chk("R3 cycles", out_cycles, m_cyc);
                else if (m_cross)   chk("R6 cycles", out_cycles, m_cyc);
                else                chk("R5 cycles", out_cycles, m_cyc);
            end
        end
    end

    // randomised consumer back-pressure
    always @(negedge clk) begin
        #1;
        if (rnd_ready) out_ready = ($urandom_range(0, 3) != 0);
    end

    task automatic drive(input logic [7:0] op, input logic [7:0] d, input logic [15:0] pc,
                         input logic [3:0] nvcz);
        @(negedge clk);
        #1;
        in_opcode = op; in_disp = d; in_pc = pc;
        {flag_n, flag_v, flag_c, flag_z} = nvcz;
        in_valid = 1'b1;
    endtask

    task automatic send(input logic [7:0] op, input logic [7:0] d, input logic [15:0] pc,
                        input logic [3:0] nvcz);
        drive(op, d, pc, nvcz);
        forever begin
            @(negedge clk);
            if (acc_seen) break;
        end
        #1 in_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] held_pc;
        logic [2:0]  held_cyc;
        repeat (3) @(negedge clk);
        chk("R1 reset valid", out_valid, 1'b0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", out_valid, 1'b0);

        // R2: every opcode against every flag pattern
        for (int k = 0; k < 8; k++)
            for (int f = 0; f < 16; f++)
                send(8'(8'h10 + 32 * k), 8'h10, 16'h2000 + 16'(f * 4), 4'(f));

        // R5 forward same page, R6 backward across page
        send(8'hF0, 8'h20, 16'h3010, 4'b0001);
        send(8'h10, 8'hF0, 16'h3002, 4'b0000);
        // R6 forward across page
        send(8'h90, 8'h7F, 16'h30C0, 4'b0000);
        // R7 self loop in page and across page; not-taken -2
        send(8'hD0, 8'hFE, 16'h4040, 4'b0000);
        send(8'hD0, 8'hFE, 16'h40FF, 4'b0000);
        send(8'hD0, 8'hFE, 16'h4040, 4'b0001);
        // R8 non-branch opcodes
        send(8'h00, 8'h12, 16'h5555, 4'b1111);
        send(8'h18, 8'hFE, 16'h1234, 4'b0000);
        send(8'h20, 8'h04, 16'hABCD, 4'b0000);
        send(8'hF1, 8'h04, 16'h0F00, 4'b0001);
        // R11 wrap at both ends
        send(8'hB0, 8'h20, 16'hFFF0, 4'b0010);
        send(8'hB0, 8'h20, 16'hFFFE, 4'b0000);
        send(8'h30, 8'hF0, 16'h0002, 4'b1000);
        send(8'h70, 8'h80, 16'h0010, 4'b0100);

        // R10 stall holds result and blocks the next request
        @(negedge clk); #1 out_ready = 1'b0;
        send(8'h50, 8'h08, 16'h6000, 4'b0000);
        drive(8'h90, 8'h08, 16'h7000, 4'b0000);
        @(negedge clk);
        held_pc  = out_next_pc;
        held_cyc = out_cycles;
        repeat (4) @(negedge clk);
        chk("R10 held next_pc", out_next_pc, held_pc);
        chk("R10 held cycles", out_cycles, held_cyc);
        chk("R10 blocked ready", in_ready, 1'b0);
        #1 out_ready = 1'b1;
        forever begin
            @(negedge clk);
            if (acc_seen) break;
        end
        #1 in_valid = 1'b0;

        // mixed traffic under back-pressure
        rnd_ready = 1;
        for (int i = 0; i < 400; i++) begin
            logic [7:0] op;
            op = ($urandom_range(0, 4) == 0) ? 8'($urandom) : 8'(8'h10 + 32 * $urandom_range(0, 7));
            send(op, 8'($urandom), 16'($urandom), 4'($urandom));
        end
        rnd_ready = 0;
        @(negedge clk); #1 out_ready = 1'b1;
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule